// File: doc/BRIEF.md
# USB Hub Downstream Port Line Signaling

This block generates the line signaling for a single downstream port of a USB hub. A register front end holds four control bits: port enable, low-speed select, forced reset and forced resume. The block turns these bits into a shared output enable and two line levels for D+ and D-. When no signaling is requested, the drivers are released.

When the port is enabled, a free-running period counter requests a keep-alive on the line once per period. A keep-alive is a low-speed end-of-packet: two bit times of SE0 followed by one bit time of J. Forced reset holds SE0 on the line and forced resume holds K, each for as long as its bit stays set. Software controls how long each one lasts. When resume ends, the block sends an end-of-packet. A fault input turns off the port enable and cuts short a keep-alive that is already on the line.

The defaults are BIT_CYC = 8 clocks per low-speed bit and KA_PERIOD = 12000 clocks. With a 12 MHz clock, these give a 1 ms keep-alive period.

Top module: `usb_dnport_sig`

## Requirements
- R1: While rst_n is low, and after the first clock edge that samples it low, port_en, line_oe, dp_out and dm_out are all 0. The low-speed, forced-reset and forced-resume bits are also cleared.
- R2: port_en becomes 1 only after a clock edge that samples en_set high while en_clr and fault_in are low. An edge that samples en_clr or fault_in high makes port_en 0, and fault_in overrides en_set. The bits ls, frst and fres load from cfg_* only at an edge that samples cfg_we high.
- R3: While port_en stays 1, a keep-alive end-of-packet starts on the line exactly KA_PERIOD cycles after the edge that set the enable, and then every KA_PERIOD cycles. The period counter restarts whenever the port is disabled.
- R4: Every end-of-packet has the same shape. It drives SE0 (line_oe=1, dp_out=0, dm_out=0) for 2*BIT_CYC cycles, then J for BIT_CYC cycles, and then releases all outputs to 0.
- R5: One cycle after the forced-reset bit is written to 1, the outputs show SE0 with line_oe=1. They keep doing so for as long as the bit is 1.
- R6: While forced resume is 1 and forced reset is 0, the outputs show K with line_oe=1.
- R7: One cycle after forced resume is cleared while forced reset is 0, an end-of-packet as described in R4 begins.
- R8: With ls=1, J is dp=0, dm=1 and K is dp=1, dm=0. With ls=0, J is dp=1, dm=0 and K is dp=0, dm=1.
- R9: Signals take priority in this order, highest first: forced reset, forced resume, an end-of-packet in progress, a keep-alive that has fallen due. A keep-alive that falls due during any higher-priority state is dropped and is not queued for later.
- R10: If fault_in is sampled high while a keep-alive end-of-packet is on the line, and neither forced bit is set, the line is released on the next cycle. An end-of-resume packet is not cut short by a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (12 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| en_set | input | 1 | Pulse that sets the port enable |
| en_clr | input | 1 | Pulse that clears the port enable |
| fault_in | input | 1 | Fault indication; clears the enable and aborts a keep-alive |
| cfg_we | input | 1 | Loads the three control bits below |
| cfg_ls | input | 1 | Low-speed select value (1 = low speed) |
| cfg_frst | input | 1 | Forced-reset value |
| cfg_fres | input | 1 | Forced-resume value |
| port_en | output | 1 | Current port enable bit |
| line_oe | output | 1 | Drive enable for both data lines |
| dp_out | output | 1 | D+ level |
| dm_out | output | 1 | D- level |

## Verification
Some properties are checked by assertions on every cycle. A fault always leaves the enable at 0 after the edge that samples it. Forced reset always produces SE0, and forced resume on its own always produces K in the selected polarity. The cycle after resume ends always starts SE0, and a faulted keep-alive always releases the line. Other behaviours can only be shown by the bench's scenarios, which compare against a reference model. These include the exact keep-alive phase against the enable edge and the 16/8 cycle shape of each end-of-packet. They also include dropped keep-alives during long forced states and the polarity change after the low-speed bit is rewritten.

// File: rtl/usb_dnport_pkg.sv
// Shared types for the downstream port signaling block.
// Assumes: nothing beyond the SystemVerilog language.
package usb_dnport_pkg;
    typedef enum logic [1:0] {
        SIG_IDLE = 2'd0,
        SIG_RST  = 2'd1,
        SIG_RES  = 2'd2,
        SIG_EOP  = 2'd3
    } sig_state_t;
endpackage

// File: rtl/dnp_ctrl_regs.sv
// Control bit storage: the port enable and the three configuration bits.
// Assumes: en_set/en_clr/fault_in/cfg_we are single-cycle synchronous pulses.
module dnp_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic fault_in,
    input  logic cfg_we,
    input  logic cfg_ls,
    input  logic cfg_frst,
    input  logic cfg_fres,
    output logic en_q,
    output logic ls_q,
    output logic frst_q,
    output logic fres_q
);
    // Enable bit: a fault or a clear wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)                  en_q <= 1'b0;
        else if (fault_in || en_clr) en_q <= 1'b0;
        else if (en_set)             en_q <= 1'b1;
    end

    // Configuration bits load only on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_q   <= 1'b0;
            frst_q <= 1'b0;
            fres_q <= 1'b0;
        end else if (cfg_we) begin
            ls_q   <= cfg_ls;
            frst_q <= cfg_frst;
            fres_q <= cfg_fres;
        end
    end

    // R2
    fault_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> !en_q);
endmodule

// File: rtl/dnp_ka_timer.sv
// Keep-alive period counter: flags due once every KA_PERIOD cycles while enabled.
// Assumes: KA_PERIOD >= 2; counter restarts from zero whenever enable is low.
module dnp_ka_timer #(
    parameter int KA_PERIOD = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic due_o
);
    localparam int CW = $clog2(KA_PERIOD);
    localparam logic [CW-1:0] LAST = CW'(KA_PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Free-running count, held at zero while the port is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)  cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    // Due flag for exactly one cycle per period.
    always_comb due_o = en_i && (cnt_q == LAST);

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/dnp_sig_fsm.sv
// Line sequencer: picks forced reset, forced resume, end-of-packet or idle
// and maps the chosen state to drive enable and line levels.
// Assumes: control inputs are registered; ka_due is a one-cycle pulse.
module dnp_sig_fsm
    import usb_dnport_pkg::*;
#(
    parameter int BIT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frst_i,
    input  logic fres_i,
    input  logic ls_i,
    input  logic ka_due_i,
    input  logic fault_i,
    output logic oe_o,
    output logic dp_o,
    output logic dm_o
);
    localparam int EOP_LEN = 3 * BIT_CYC;
    localparam int EW      = $clog2(EOP_LEN);
    localparam logic [EW-1:0] E_LAST = EW'(EOP_LEN - 1);
    localparam logic [EW-1:0] E_JSTART = EW'(2 * BIT_CYC);

    sig_state_t    st_q;
    logic [EW-1:0] ecnt_q;
    logic          eop_ka_q;

    // State update in priority order: reset, resume, EOP, keep-alive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SIG_IDLE;
            ecnt_q   <= '0;
            eop_ka_q <= 1'b0;
        end else if (frst_i) begin
            st_q <= SIG_RST;
        end else if (fres_i) begin
            st_q <= SIG_RES;
        end else if (st_q == SIG_RES) begin
            st_q     <= SIG_EOP;
            ecnt_q   <= '0;
            eop_ka_q <= 1'b0;
        end else if (st_q == SIG_EOP) begin
            if ((fault_i && eop_ka_q) || ecnt_q == E_LAST) begin
                st_q <= SIG_IDLE;
            end else begin
                ecnt_q <= ecnt_q + 1'b1;
            end
        end else if (ka_due_i && !fault_i) begin
            st_q     <= SIG_EOP;
            ecnt_q   <= '0;
            eop_ka_q <= 1'b1;
        end else begin
            st_q <= SIG_IDLE;
        end
    end

    // Output map: J/K polarity follows the low-speed select.
    always_comb begin
        oe_o = 1'b0;
        dp_o = 1'b0;
        dm_o = 1'b0;
        case (st_q)
            SIG_RST: oe_o = 1'b1;
            SIG_RES: begin
                oe_o = 1'b1;
                dp_o = ls_i;
                dm_o = !ls_i;
            end
            SIG_EOP: begin
                oe_o = 1'b1;
                if (ecnt_q >= E_JSTART) begin
                    dp_o = !ls_i;
                    dm_o = ls_i;
                end
            end
            default: ;
        endcase
    end

    // R5
    rst_drives_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frst_i |=> (oe_o && !dp_o && !dm_o));
    // R6
    res_drives_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fres_i && !frst_i) |=> (oe_o && dp_o == ls_i && dm_o == !ls_i));
    // R7
    res_end_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SIG_RES && !fres_i && !frst_i) |=> (oe_o && !dp_o && !dm_o));
    // R10
    fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SIG_EOP && eop_ka_q && fault_i && !frst_i && !fres_i) |=> !oe_o);
endmodule

// File: rtl/usb_dnport_sig.sv
// Top: downstream port signaling. Joins the control registers, the keep-alive
// timer and the line sequencer.
// Assumes: one clock domain; BIT_CYC clocks per low-speed bit.
module usb_dnport_sig #(
    parameter int BIT_CYC   = 8,
    parameter int KA_PERIOD = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic fault_in,
    input  logic cfg_we,
    input  logic cfg_ls,
    input  logic cfg_frst,
    input  logic cfg_fres,
    output logic port_en,
    output logic line_oe,
    output logic dp_out,
    output logic dm_out
);
    logic en_w, ls_w, frst_w, fres_w, due_w;

    dnp_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .fault_in(fault_in), .cfg_we(cfg_we), .cfg_ls(cfg_ls),
        .cfg_frst(cfg_frst), .cfg_fres(cfg_fres),
        .en_q(en_w), .ls_q(ls_w), .frst_q(frst_w), .fres_q(fres_w)
    );

    dnp_ka_timer #(.KA_PERIOD(KA_PERIOD)) u_timer (
        .clk(clk), .rst_n(rst_n), .en_i(en_w), .due_o(due_w)
    );

    dnp_sig_fsm #(.BIT_CYC(BIT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frst_i(frst_w), .fres_i(fres_w),
        .ls_i(ls_w), .ka_due_i(due_w), .fault_i(fault_in),
        .oe_o(line_oe), .dp_o(dp_out), .dm_o(dm_out)
    );

    // Enable bit is visible at the port.
    always_comb port_en = en_w;

    // R1
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> (!port_en && !line_oe));
endmodule

// File: tb/tb_usb_dnport_sig.sv
module tb_usb_dnport_sig;
    localparam int BIT = 8;
    localparam int PER = 300;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en_set = 0, en_clr = 0, fault_in = 0, cfg_we = 0;
    logic cfg_ls = 0, cfg_frst = 0, cfg_fres = 0;
    logic port_en, line_oe, dp_out, dm_out;

    int checks = 0, errors = 0, cyc = 0;
    string phase = "";

    usb_dnport_sig #(.BIT_CYC(BIT), .KA_PERIOD(PER)) dut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .fault_in(fault_in), .cfg_we(cfg_we), .cfg_ls(cfg_ls),
        .cfg_frst(cfg_frst), .cfg_fres(cfg_fres), .port_en(port_en),
        .line_oe(line_oe), .dp_out(dp_out), .dm_out(dm_out)
    );

    always #10 clk = ~clk;

    // Reference model state (0 idle, 1 reset, 2 resume, 3 eop)
    logic m_en = 0, m_ls = 0, m_frst = 0, m_fres = 0, m_ka = 0;
    int   m_cnt = 0, m_st = 0, m_ec = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_en <= 0; m_ls <= 0; m_frst <= 0; m_fres <= 0;
            m_cnt <= 0; m_st <= 0; m_ec <= 0; m_ka <= 0;
        end else begin
            if (fault_in || en_clr) m_en <= 0;
            else if (en_set)        m_en <= 1;
            if (cfg_we) begin
                m_ls <= cfg_ls; m_frst <= cfg_frst; m_fres <= cfg_fres;
            end
            if (!m_en || m_cnt == PER - 1) m_cnt <= 0;
            else                           m_cnt <= m_cnt + 1;
            if (m_frst)           m_st <= 1;
            else if (m_fres)      m_st <= 2;
            else if (m_st == 2) begin m_st <= 3; m_ec <= 0; m_ka <= 0; end
            else if (m_st == 3) begin
                if ((fault_in && m_ka) || m_ec == 3 * BIT - 1) m_st <= 0;
                else m_ec <= m_ec + 1;
            end else if (m_en && m_cnt == PER - 1 && !fault_in) begin
                m_st <= 3; m_ec <= 0; m_ka <= 1;
            end else m_st <= 0;
        end
    end

    function automatic logic [2:0] exp_line();
        case (m_st)
            1: return 3'b100;
            2: return {1'b1, m_ls, !m_ls};
            3: return (m_ec < 2 * BIT) ? 3'b100 : {1'b1, !m_ls, m_ls};
            default: return 3'b000;
        endcase
    endfunction

    function automatic string state_tag();
        case (m_st)
            1: return "R5";
            2: return "R6";
            3: return m_ka ? "R3" : "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic compare();
        string t = (phase != "") ? phase : state_tag();
        logic [2:0] e = exp_line();
        checks++;
        if ({line_oe, dp_out, dm_out} !== e) begin
            errors++;
            $display("FAIL %s cyc %0d line oe/dp/dm actual %b expected %b",
                     t, cyc, {line_oe, dp_out, dm_out}, e);
        end
        checks++;
        if (port_en !== m_en) begin
            errors++;
            $display("FAIL R2 cyc %0d port_en actual %b expected %b", cyc, port_en, m_en);
        end
    endtask

    // One cycle: inputs already driven; compare after the next edge; clear pulses.
    task automatic tick();
        @(negedge clk);
        compare();
        en_set = 0; en_clr = 0; fault_in = 0; cfg_we = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_cfg(logic ls, logic fr, logic rs);
        cfg_we = 1; cfg_ls = ls; cfg_frst = fr; cfg_fres = rs;
        tick();
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        phase = "R1";
        run(4);
        rst_n = 1;
        phase = "R1";
        run(2);
        // R3 keep-alive phase after enable, then R4 EOP shape
        en_set = 1; phase = "R3"; tick();
        run(PER - 2);
        phase = "R4"; run(40);
        // R8 low-speed polarity on next keep-alive
        wr_cfg(1, 0, 0);
        phase = "R8"; run(PER);
        // R9 forced reset spans a due keep-alive; it is dropped
        wr_cfg(1, 1, 0);
        phase = "R9"; run(PER + 20);
        wr_cfg(1, 0, 1);
        phase = "R6"; run(30);
        wr_cfg(0, 0, 0);
        phase = "R7"; run(40);
        // R10 fault in the middle of a keep-alive
        phase = "R10";
        while (!(m_st == 3 && m_ka && m_ec == 5)) tick();
        fault_in = 1; tick();
        run(10);
        // R2 enable clear, then re-enable
        phase = "R2";
        en_clr = 1; tick(); run(3);
        en_set = 1; fault_in = 1; tick(); run(3);
        en_set = 1; tick();
        // Random mix
        phase = "";
        for (int i = 0; i < 40000; i++) begin
            if ($urandom_range(99) < 2) en_set = 1;
            if ($urandom_range(999) < 3) en_clr = 1;
            if ($urandom_range(999) < 4) fault_in = 1;
            if ($urandom_range(999) < 6) begin
                cfg_we = 1;
                cfg_ls = 1'($urandom_range(1));
                cfg_frst = ($urandom_range(99) < 15);
                cfg_fres = ($urandom_range(99) < 30);
            end
            tick();
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule